// File: doc/BRIEF.md
# CAN Node Operating Mode Sequencer

This block owns the operating state of a CAN node and sits between the protocol core and the bus pins. Software asks for configuration or low-power operation through two request levels. The sequencer moves through four states and reports the state it has reached on three status bits. A status bit changes only once the transition it reports has completed.

The four states are INIT, SLEEP, SYNC and NORMAL. Reset enters INIT. In INIT no frames are exchanged. SLEEP gates the core clock. The mailbox registers stay readable because they run outside the gated core. SYNC waits for a run of recessive bits before the node joins traffic. NORMAL carries frames.

The transitions are:
- INIT to SYNC when the configuration request drops.
- INIT to SLEEP when the configuration request drops while the sleep request is active.
- SYNC to NORMAL after eleven consecutive recessive bits.
- SYNC or NORMAL to INIT on a configuration request.
- SYNC or NORMAL to SLEEP on a sleep request.
- SLEEP to INIT on a configuration request.
- SLEEP to SYNC on a software release or on bus activity.

Two test sub-modes reroute the paths and can be combined. Silent mode holds the pin recessive and suppresses acknowledge and error frames. Loopback mode feeds the core's transmit stream back to its receiver.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the state is INIT: stat_init=1, stat_sleep=0, stat_normal=0, bus_tx=1, core_rx=1, core_clk_en=1.
- R2: The configuration request has priority. When req_init=1 at a clock edge, the state is INIT after that edge, whatever the other inputs are.
- R3: When req_init is low, INIT goes to SYNC if the sleep request is inactive and to SLEEP if it is active. The status bits change one clock after the request changes.
- R4: NORMAL is entered only from SYNC. The entry happens one clock after the eleventh consecutive bit_tick that samples a recessive (1) receive view. A dominant (0) sample on a bit_tick restarts the count.
- R5: In SLEEP, core_clk_en=0 and stat_sleep=1. In every other state, core_clk_en=1.
- R6: In SLEEP, a falling edge (1 to 0) on bus_rx moves the state to SYNC one clock later. The sleep request is then ignored until software lowers it.
- R7: In SLEEP, lowering req_sleep moves the state to SYNC one clock later.
- R8: A falling edge on bus_rx in INIT or NORMAL does not change the state.
- R9: With cfg_silent=1, bus_tx=1 always, ack_inhibit=1 and errframe_inhibit=1. With cfg_silent=0 in NORMAL, bus_tx follows core_tx and both inhibits are 0.
- R10: In SYNC and NORMAL, core_rx follows core_tx when cfg_loopback=1 and follows bus_rx when cfg_loopback=0. In INIT and SLEEP, core_rx=1. The SYNC recessive count uses this same receive view.
- R11: Outside NORMAL, bus_tx=1 and both inhibits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| req_init | input | 1 | Software configuration request (level) |
| req_sleep | input | 1 | Software sleep request (level) |
| cfg_silent | input | 1 | Silent sub-mode enable |
| cfg_loopback | input | 1 | Loopback sub-mode enable |
| bus_rx | input | 1 | Raw bus receive line |
| core_tx | input | 1 | Transmit bit stream from the protocol core |
| bus_tx | output | 1 | Bus transmit line |
| core_rx | output | 1 | Receive bit stream to the protocol core |
| core_clk_en | output | 1 | Clock enable for the protocol core |
| ack_inhibit | output | 1 | Suppresses acknowledge bits |
| errframe_inhibit | output | 1 | Suppresses error frames |
| stat_init | output | 1 | State is INIT |
| stat_sleep | output | 1 | State is SLEEP |
| stat_normal | output | 1 | State is NORMAL |

## Verification
The assertions check several rules on every cycle:
- the priority of the configuration request;
- that NORMAL is entered only after a full recessive run;
- that bus activity wakes a sleeping node;
- that silent mode keeps the pin recessive;
- that loopback routes the receive view.

Only the bench scenarios show the following:
- that the recessive count restarts on a dominant bit;
- that the wake latch holds off the sleep request until software lowers it;
- that edges outside SLEEP are ignored;
- the exact cycle at which each status bit changes.

Random stimulus in NORMAL covers all four sub-mode combinations against a bench reference model.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SYNC   = 2'd2,
        ST_NORMAL = 2'd3
    } node_state_e;
endpackage

// File: rtl/can_wake_det.sv
module can_wake_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rx,
    input  logic asleep,
    input  logic req_init,
    input  logic req_sleep,
    output logic wake_pulse,
    output logic sleep_eff
);
    logic rx_q;
    logic wake_hold;

    assign wake_pulse = asleep & rx_q & ~bus_rx;
    assign sleep_eff  = req_sleep & ~wake_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= 1'b1;
            wake_hold <= 1'b0;
        end else begin
            rx_q <= bus_rx;
            if (!req_sleep)
                wake_hold <= 1'b0;
            else if (wake_pulse && !req_init)
                wake_hold <= 1'b1;
        end
    end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
#(
    parameter int SYNC_BITS = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        rx_view,
    input  logic        req_init,
    input  logic        sleep_eff,
    input  logic        wake_pulse,
    input  logic        req_sleep,
    output node_state_e state
);
    localparam int CNT_W = $clog2(SYNC_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_BITS - 1);

    node_state_e      state_nx;
    logic [CNT_W-1:0] rec_cnt;
    logic             run_done;

    assign run_done = bit_tick && rx_view && (rec_cnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: begin
                if (!req_init) state_nx = sleep_eff ? ST_SLEEP : ST_SYNC;
            end
            ST_SLEEP: begin
                if (req_init)                     state_nx = ST_INIT;
                else if (!req_sleep || wake_pulse) state_nx = ST_SYNC;
            end
            ST_SYNC: begin
                if (req_init)       state_nx = ST_INIT;
                else if (sleep_eff) state_nx = ST_SLEEP;
                else if (run_done)  state_nx = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (req_init)       state_nx = ST_INIT;
                else if (sleep_eff) state_nx = ST_SLEEP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_INIT;
            rec_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state != ST_SYNC)
                rec_cnt <= '0;
            else if (bit_tick)
                rec_cnt <= rx_view ? rec_cnt + 1'b1 : '0;
        end
    end

    // R2
    init_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_init |=> state == ST_INIT);

    // R4
    sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && $past(state) != ST_NORMAL) |->
            ($past(state) == ST_SYNC && $past(rec_cnt) == LAST && $past(rx_view)));

    // R6
    bus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_pulse && !req_init) |=> state == ST_SYNC);
endmodule

// File: rtl/can_path_mux.sv
module can_path_mux
    import can_mode_pkg::*;
(
    input  node_state_e state,
    input  logic        cfg_silent,
    input  logic        cfg_loopback,
    input  logic        bus_rx,
    input  logic        core_tx,
    output logic        bus_tx,
    output logic        core_rx,
    output logic        inhibit
);
    logic on_bus;
    logic active;

    assign active = (state == ST_SYNC) || (state == ST_NORMAL);
    assign on_bus = (state == ST_NORMAL) && !cfg_silent;

    always_comb begin
        bus_tx  = on_bus ? core_tx : 1'b1;
        inhibit = !on_bus;
        if (!active)
            core_rx = 1'b1;
        else
            core_rx = cfg_loopback ? core_tx : bus_rx;
    end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int SYNC_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic req_init,
    input  logic req_sleep,
    input  logic cfg_silent,
    input  logic cfg_loopback,
    input  logic bus_rx,
    input  logic core_tx,
    output logic bus_tx,
    output logic core_rx,
    output logic core_clk_en,
    output logic ack_inhibit,
    output logic errframe_inhibit,
    output logic stat_init,
    output logic stat_sleep,
    output logic stat_normal
);
    node_state_e state;
    logic        wake_pulse;
    logic        sleep_eff;
    logic        inhibit;

    can_wake_det u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rx     (bus_rx),
        .asleep     (state == ST_SLEEP),
        .req_init   (req_init),
        .req_sleep  (req_sleep),
        .wake_pulse (wake_pulse),
        .sleep_eff  (sleep_eff)
    );

    can_mode_fsm #(.SYNC_BITS(SYNC_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_view    (core_rx),
        .req_init   (req_init),
        .sleep_eff  (sleep_eff),
        .wake_pulse (wake_pulse),
        .req_sleep  (req_sleep),
        .state      (state)
    );

    can_path_mux u_mux (
        .state        (state),
        .cfg_silent   (cfg_silent),
        .cfg_loopback (cfg_loopback),
        .bus_rx       (bus_rx),
        .core_tx      (core_tx),
        .bus_tx       (bus_tx),
        .core_rx      (core_rx),
        .inhibit      (inhibit)
    );

    always_comb begin
        core_clk_en      = (state != ST_SLEEP);
        ack_inhibit      = inhibit;
        errframe_inhibit = inhibit;
        stat_init        = (state == ST_INIT);
        stat_sleep       = (state == ST_SLEEP);
        stat_normal      = (state == ST_NORMAL);
    end

    // R9
    silent_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_silent |-> (bus_tx && ack_inhibit && errframe_inhibit));

    // R10
    loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loopback && (stat_normal || (!stat_init && !stat_sleep))) |-> core_rx == core_tx);

    // R5
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_init, stat_sleep, stat_normal}) && (stat_sleep == !core_clk_en));
endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, req_init = 1'b1, req_sleep = 1'b0;
    logic cfg_silent = 1'b0, cfg_loopback = 1'b0, bus_rx = 1'b1, core_tx = 1'b1;
    logic bus_tx, core_rx, core_clk_en, ack_inhibit, errframe_inhibit;
    logic stat_init, stat_sleep, stat_normal;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_mode_seq u_dut (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input logic rx);
        bus_rx = rx; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    function automatic logic exp_tx(input logic sil, input logic tx);
        return sil ? 1'b1 : tx;
    endfunction

    function automatic logic exp_rx(input logic lb, input logic tx, input logic rx);
        return lb ? tx : rx;
    endfunction

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1
        chk("R1 stat_init", stat_init, 1'b1);
        chk("R1 stat_sleep", stat_sleep, 1'b0);
        chk("R1 bus_tx", bus_tx, 1'b1);
        chk("R1 core_rx", core_rx, 1'b1);
        chk("R1 clk_en", core_clk_en, 1'b1);
        // R8 falling edge in INIT ignored
        bus_rx = 1'b0; step(1); bus_rx = 1'b1; step(1);
        chk("R8 init kept", stat_init, 1'b1);

        // R3 leave INIT -> SYNC
        req_init = 1'b0; step(1);
        chk("R3 init cleared", stat_init, 1'b0);
        chk("R3 not sleeping", stat_sleep, 1'b0);
        // R11 outside NORMAL
        core_tx = 1'b0;
        chk("R11 tx recessive in sync", bus_tx, 1'b1);
        chk("R11 inhibit in sync", ack_inhibit, 1'b1);
        core_tx = 1'b1;
        // R4 count restart
        for (int i = 0; i < 8; i++) tick(1'b1);
        tick(1'b0);
        for (int i = 0; i < 10; i++) tick(1'b1);
        chk("R4 not normal after 10", stat_normal, 1'b0);
        tick(1'b1);
        chk("R4 normal after 11", stat_normal, 1'b1);
        // R9 silent off: follows core
        core_tx = 1'b0; step(1);
        chk("R9 bus_tx follows", bus_tx, 1'b0);
        chk("R9 ack inhibit off", ack_inhibit, 1'b0);
        cfg_silent = 1'b1; step(1);
        chk("R9 silent pin", bus_tx, 1'b1);
        chk("R9 errframe inhibit", errframe_inhibit, 1'b1);
        // R10 loopback
        cfg_loopback = 1'b1; bus_rx = 1'b1; step(1);
        chk("R10 loop view", core_rx, 1'b0);
        cfg_silent = 1'b0; cfg_loopback = 1'b0; core_tx = 1'b1;
        // R8 edge in NORMAL
        bus_rx = 1'b0; step(1); bus_rx = 1'b1; step(1);
        chk("R8 normal kept", stat_normal, 1'b1);

        // random NORMAL routing, R9 R10
        begin
            int unsigned seed = 32'd1234;
            void'($urandom(seed));
            for (int i = 0; i < 200; i++) begin
                cfg_silent = 1'($urandom); cfg_loopback = 1'($urandom);
                core_tx = 1'($urandom); bus_rx = 1'($urandom);
                step(1);
                chk("R9 random tx", bus_tx, exp_tx(cfg_silent, core_tx));
                chk("R10 random rx", core_rx, exp_rx(cfg_loopback, core_tx, bus_rx));
                chk("R9 random inhibit", ack_inhibit, cfg_silent);
            end
            cfg_silent = 1'b0; cfg_loopback = 1'b0; core_tx = 1'b1; bus_rx = 1'b1;
            step(1);
            chk("R8 still normal", stat_normal, 1'b1);
        end

        // R5 sleep from NORMAL
        req_sleep = 1'b1; step(1);
        chk("R5 stat_sleep", stat_sleep, 1'b1);
        chk("R5 clk gated", core_clk_en, 1'b0);
        chk("R10 rx idle in sleep", core_rx, 1'b1);
        // R6 bus wake
        bus_rx = 1'b0; step(1);
        chk("R6 woke", stat_sleep, 1'b0);
        chk("R6 clk on", core_clk_en, 1'b1);
        bus_rx = 1'b1;
        for (int i = 0; i < 11; i++) tick(1'b1);
        chk("R6 sleep req held off", stat_normal, 1'b1);
        // R7 software wake
        req_sleep = 1'b0; step(1);
        req_sleep = 1'b1; step(1);
        chk("R7 asleep again", stat_sleep, 1'b1);
        req_sleep = 1'b0; step(1);
        chk("R7 sw wake", stat_sleep, 1'b0);
        chk("R7 in sync", stat_normal, 1'b0);
        // R10 loopback sync uses core view: bus dominant ignored
        cfg_loopback = 1'b1;
        for (int i = 0; i < 11; i++) tick(1'b0);
        chk("R10 loop sync", stat_normal, 1'b1);
        cfg_loopback = 1'b0; bus_rx = 1'b1;
        // R2 init priority over sleep
        req_init = 1'b1; req_sleep = 1'b1; step(1);
        chk("R2 init wins", stat_init, 1'b1);
        chk("R2 not asleep", stat_sleep, 1'b0);
        // R3 INIT -> SLEEP
        req_init = 1'b0; step(1);
        chk("R3 init to sleep", stat_sleep, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule